// File: doc/BRIEF.md
# TDM Multi-Stream Slot Transmitter

This block places a set of sense and status samples onto one shared serial data-out line of a time-division-multiplexed audio bus. The frame is cut into 8-bit transmit slots. Each of seven streams (voltage sense, current sense, two supply-voltage readings, die temperature, limiter gain and a status byte) has its own enable and a 6-bit starting slot. An enabled stream fills one, two or three consecutive slots, most significant bit first. Every bit that no enabled stream owns is either driven low or released, as a fill bit selects. A separate output-enable tells the pad when to drive.

The block runs on a fast system clock. It oversamples the bus bit clock and the frame sync. A configuration bit picks whether data is launched on the rising or the falling bit-clock edge. A 3-bit offset sets how many bit clocks pass from the frame-start edge to the first bit of slot 0. All stream samples are copied into a shadow set when a frame starts, so one frame always carries one coherent set of values. Several devices can share the line, each placing its streams in its own slots and releasing the others.

Top module: `tdm_stream_tx`

## Requirements
- R1: While `rst_n` is low, and until the first launch edge after it, `sdout_o` and `sdout_oe_o` are 0. Until the first frame start, every launch edge puts out fill.
- R2: Outputs change only on a launch edge. With `tx_fall_i`=0 this is a rising edge of `bclk_i`, with `tx_fall_i`=1 a falling edge. A frame starts on the launch edge where `fsync_i` is 1 and it was 0 at the previous launch edge.
- R3: The bit launched at frame-start edge number n (frame-start edge = 0) is frame bit k = n − `slot_ofs_i`. Slot s covers k = 8s..8s+7, and each stream puts its MSB first. Stream n's start slot is `slot_idx_i[6n+5:6n]`. The stream numbers are voltage 0, current 1, supply-1 2, supply-2 3, temperature 4, gain 5, status 6, and `stream_en_i[n]` enables stream n.
- R4: With `iv_len_i`=00 (or 11), voltage and current each send all 16 bits over two slots.
- R5: Supply stream j (j=0 for supply-1, 1 for supply-2) sends its 10 bits left-justified in 16 bits over two slots when `sup_short_i[j]`=0. When it is 1, it sends only its top 8 bits in one slot.
- R6: Temperature, gain and status each send 8 bits in one slot. A stream whose enable is 0 owns no bits.
- R7: On an unowned bit, `sdout_o`=0. `sdout_oe_o`=1 when `fill_hiz_i`=0 and 0 when `fill_hiz_i`=1. On an owned bit, `sdout_oe_o`=1.
- R8: A new frame start restarts the bit count at 0, which cuts off any stream still in progress. Bits that fall before the offset, or after the last owned slot, are fill.
- R9: With `iv_len_i`=01, voltage and current each send their top 8 bits in one slot.
- R10: With `iv_len_i`=10, the voltage stream fills three slots from its start slot with voltage bits 15..4 followed by current bits 15..4. The current stream's own slot index and enable are then ignored.
- R11: Where enabled streams overlap, the bit comes from the lowest-numbered stream (voltage highest priority, status lowest).
- R12: Stream samples are captured at each frame start. Input changes later in the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bus bit clock, sampled by clk |
| fsync_i | input | 1 | Frame sync, sampled on launch edges |
| tx_fall_i | input | 1 | 1: launch on falling bit-clock edge |
| slot_ofs_i | input | 3 | Bit clocks from frame start to slot 0 |
| fill_hiz_i | input | 1 | 1: release unowned bits, 0: drive them low |
| iv_len_i | input | 2 | Voltage/current length: 00 16-bit, 01 8-bit, 10 packed 12-bit |
| sup_short_i | input | 2 | Per supply stream: 1 sends one slot of 8 MSBs |
| stream_en_i | input | 7 | Per-stream transmit enable |
| slot_idx_i | input | 42 | Seven 6-bit starting slots, stream n at bits 6n+5:6n |
| vsns_i | input | 16 | Voltage-sense sample |
| isns_i | input | 16 | Current-sense sample |
| sup1_i | input | 10 | Supply-1 voltage sample |
| sup2_i | input | 10 | Supply-2 voltage sample |
| temp_i | input | 8 | Die temperature sample |
| gain_i | input | 8 | Limiter gain sample |
| stat_i | input | 8 | Status byte |
| sdout_o | output | 1 | Serial data out |
| sdout_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
A wrong bit counter or a frame start that is missed shows up as a shift of the whole slot map. This is visible at the ports on the first owned bit after the faulty edge, at most one bit clock later. A bad shadow capture or a wrong priority choice corrupts exactly the bits of the affected slot in the same frame. A wrong fill decision shows up on `sdout_oe_o` at the next unowned bit. The reference model paints an independent bit map of each frame and checks both outputs on every system clock, so any of these faults is reported within a few clocks of the edge that exposes it.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int SLOT_W  = 8;
    localparam int WORD_W  = 3 * SLOT_W;
    localparam int NSTREAM = 7;

    localparam int S_V  = 0;
    localparam int S_I  = 1;
    localparam int S_P1 = 2;
    localparam int S_P2 = 3;
    localparam int S_T  = 4;
    localparam int S_G  = 5;
    localparam int S_ST = 6;

    typedef enum logic [1:0] {
        IV_FULL = 2'b00,
        IV_BYTE = 2'b01,
        IV_PACK = 2'b10,
        IV_RSVD = 2'b11
    } iv_len_e;

    typedef struct packed {
        logic [15:0] v;
        logic [15:0] i;
        logic [9:0]  p1;
        logic [9:0]  p2;
        logic [7:0]  t;
        logic [7:0]  g;
        logic [7:0]  st;
    } tx_sample_t;

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             fsync_i,
    input  logic             launch_fall_i,
    output logic             launch_o,
    output logic             frame_o,
    output logic [CNT_W-1:0] cnt_next_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             bclk;
        logic             fs_prev;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bclk = bclk_i;
        launch_o  = launch_fall_i ? (st_q.bclk & ~bclk_i) : (~st_q.bclk & bclk_i);
        frame_o   = launch_o & fsync_i & ~st_q.fs_prev;
        if (launch_o) begin
            st_d.fs_prev = fsync_i;
            if (frame_o) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        cnt_next_o = st_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bclk    <= 1'b0;
            st_q.fs_prev <= 1'b0;
            st_q.cnt     <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a frame start restarts the count at zero
    p_frame_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> (st_q.cnt == '0));

    // R2: the count never moves between launch edges
    p_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_o |=> $stable(st_q.cnt));

endmodule

// File: rtl/tdm_slot_lane.sv
module tdm_slot_lane #(
    parameter int CNT_W  = 10,
    parameter int IDX_W  = 6,
    parameter int SLOT_W = 8,
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        nslots_i,
    input  logic [IDX_W-1:0]  start_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  pos_i,
    input  logic              pos_ok_i,
    output logic              own_o,
    output logic              bit_o
);

    logic [CNT_W-1:0]  lo, hi, rel;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        lo      = CNT_W'(start_i) * CNT_W'(SLOT_W);
        hi      = lo + CNT_W'(nslots_i) * CNT_W'(SLOT_W);
        rel     = pos_i - lo;
        own_o   = en_i & pos_ok_i & (pos_i >= lo) & (pos_i < hi);
        shifted = word_i << rel;
        bit_o   = own_o & shifted[WORD_W-1];
    end

endmodule

// File: rtl/tdm_stream_tx.sv
module tdm_stream_tx
    import tdm_tx_pkg::*;
#(
    parameter int OFS_W = 3,
    parameter int IDX_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bclk_i,
    input  logic                       fsync_i,
    input  logic                       tx_fall_i,
    input  logic [OFS_W-1:0]           slot_ofs_i,
    input  logic                       fill_hiz_i,
    input  logic [1:0]                 iv_len_i,
    input  logic [1:0]                 sup_short_i,
    input  logic [NSTREAM-1:0]         stream_en_i,
    input  logic [NSTREAM*IDX_W-1:0]   slot_idx_i,
    input  logic [15:0]                vsns_i,
    input  logic [15:0]                isns_i,
    input  logic [9:0]                 sup1_i,
    input  logic [9:0]                 sup2_i,
    input  logic [7:0]                 temp_i,
    input  logic [7:0]                 gain_i,
    input  logic [7:0]                 stat_i,
    output logic                       sdout_o,
    output logic                       sdout_oe_o
);

    localparam int MAX_POS = (1 << OFS_W) - 1 + ((1 << IDX_W) + 3) * SLOT_W;
    localparam int CNT_W   = $clog2(MAX_POS + 1);

    typedef struct packed {
        tx_sample_t smp;
        logic       sd;
        logic       oe;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic             launch, frame;
    logic [CNT_W-1:0] cnt_next, pos;
    logic             pos_ok;

    tx_sample_t live, src;
    logic [WORD_W-1:0]  word  [NSTREAM];
    logic [1:0]         nsl   [NSTREAM];
    logic [NSTREAM-1:0] en_eff, own, lane_bit, grant;
    logic               hit, pick;

    tdm_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_i        (bclk_i),
        .fsync_i       (fsync_i),
        .launch_fall_i (tx_fall_i),
        .launch_o      (launch),
        .frame_o       (frame),
        .cnt_next_o    (cnt_next)
    );

    // stream words, left-justified, with their slot counts
    always_comb begin
        live   = {vsns_i, isns_i, sup1_i, sup2_i, temp_i, gain_i, stat_i};
        src    = frame ? live : st_q.smp;
        pos    = cnt_next - CNT_W'(slot_ofs_i);
        pos_ok = cnt_next >= CNT_W'(slot_ofs_i);
        en_eff = stream_en_i;

        case (iv_len_e'(iv_len_i))
            IV_BYTE: begin
                word[S_V] = {src.v[15:8], 16'b0};  nsl[S_V] = 2'd1;
                word[S_I] = {src.i[15:8], 16'b0};  nsl[S_I] = 2'd1;
            end
            IV_PACK: begin
                word[S_V] = {src.v[15:4], src.i[15:4]};  nsl[S_V] = 2'd3;
                word[S_I] = '0;                         nsl[S_I] = 2'd0;
                en_eff[S_I] = 1'b0;
            end
            default: begin
                word[S_V] = {src.v, 8'b0};  nsl[S_V] = 2'd2;
                word[S_I] = {src.i, 8'b0};  nsl[S_I] = 2'd2;
            end
        endcase

        word[S_P1] = sup_short_i[0] ? {src.p1[9:2], 16'b0} : {src.p1, 14'b0};
        nsl[S_P1]  = sup_short_i[0] ? 2'd1 : 2'd2;
        word[S_P2] = sup_short_i[1] ? {src.p2[9:2], 16'b0} : {src.p2, 14'b0};
        nsl[S_P2]  = sup_short_i[1] ? 2'd1 : 2'd2;
        word[S_T]  = {src.t,  16'b0};  nsl[S_T]  = 2'd1;
        word[S_G]  = {src.g,  16'b0};  nsl[S_G]  = 2'd1;
        word[S_ST] = {src.st, 16'b0};  nsl[S_ST] = 2'd1;
    end

    for (genvar n = 0; n < NSTREAM; n++) begin : g_lane
        tdm_slot_lane #(
            .CNT_W  (CNT_W),
            .IDX_W  (IDX_W),
            .SLOT_W (SLOT_W),
            .WORD_W (WORD_W)
        ) u_lane (
            .word_i   (word[n]),
            .nslots_i (nsl[n]),
            .start_i  (slot_idx_i[n*IDX_W +: IDX_W]),
            .en_i     (en_eff[n]),
            .pos_i    (pos),
            .pos_ok_i (pos_ok),
            .own_o    (own[n]),
            .bit_o    (lane_bit[n])
        );
    end

    // fixed priority: lowest stream number wins an overlapped bit
    always_comb begin
        grant = '0;
        hit   = 1'b0;
        pick  = 1'b0;
        for (int n = 0; n < NSTREAM; n++) begin
            if (!hit && own[n]) begin
                grant[n] = 1'b1;
                hit      = 1'b1;
                pick     = lane_bit[n];
            end
        end

        st_d = st_q;
        if (frame) begin
            st_d.smp = live;
        end
        if (launch) begin
            st_d.sd = hit & pick;
            st_d.oe = hit | ~fill_hiz_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdout_o    = st_q.sd;
    assign sdout_oe_o = st_q.oe;

    // R2: the line holds its value between launch edges
    p_hold_off_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(sdout_o) && $stable(sdout_oe_o)));

    // R7: an owned bit is always driven
    p_owned_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && hit) |=> sdout_oe_o);

    // R7: unowned bits in release mode leave the line undriven and low
    p_release_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !hit && fill_hiz_i) |=> (!sdout_oe_o && !sdout_o));

    // R7: unowned bits in zero mode drive a low level
    p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !hit && !fill_hiz_i) |=> (sdout_oe_o && !sdout_o));

    // R11: at most one stream is granted a bit
    p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: in packed mode the current lane never claims a bit
    p_pack_mutes_current_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_len_i == IV_PACK) |-> !own[S_I]);

    // R12: the shadow samples move only at a frame start
    p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame |=> $stable(st_q.smp));

endmodule

// File: tb/tdm_stream_tx_tb.sv
module tdm_stream_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        tx_fall = 1'b0;
    logic [2:0]  slot_ofs = 3'd0;
    logic        fill_hiz = 1'b0;
    logic [1:0]  iv_len = 2'b00;
    logic [1:0]  sup_short = 2'b00;
    logic [6:0]  stream_en = 7'b0;
    logic [41:0] slot_idx = '0;
    logic [15:0] vsns = 16'h0, isns = 16'h0;
    logic [9:0]  sup1 = 10'h0, sup2 = 10'h0;
    logic [7:0]  temp = 8'h0, gain = 8'h0, stat = 8'h0;
    logic        sdout, sdout_oe;

    always #5 clk = ~clk;

    tdm_stream_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync),
        .tx_fall_i(tx_fall), .slot_ofs_i(slot_ofs), .fill_hiz_i(fill_hiz),
        .iv_len_i(iv_len), .sup_short_i(sup_short), .stream_en_i(stream_en),
        .slot_idx_i(slot_idx), .vsns_i(vsns), .isns_i(isns), .sup1_i(sup1),
        .sup2_i(sup2), .temp_i(temp), .gain_i(gain), .stat_i(stat),
        .sdout_o(sdout), .sdout_oe_o(sdout_oe)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    bit m_own [1024];
    bit m_bit [1024];
    bit m_prev_b, m_prev_fs;
    int m_cnt;
    bit exp_sd, exp_oe;

    function automatic int start_of(int n);
        return int'(slot_idx[n*6 +: 6]);
    endfunction

    task automatic put(int slot, logic [23:0] w, int nbits);
        for (int b = 0; b < nbits; b++) begin
            int k = slot * 8 + b;
            if (k < 1024) begin
                m_own[k] = 1'b1;
                m_bit[k] = w[23-b];
            end
        end
    endtask

    // paint from lowest priority upward so higher streams overwrite
    task automatic paint_frame();
        for (int k = 0; k < 1024; k++) begin
            m_own[k] = 1'b0;
            m_bit[k] = 1'b0;
        end
        if (stream_en[6]) put(start_of(6), {stat, 16'b0}, 8);
        if (stream_en[5]) put(start_of(5), {gain, 16'b0}, 8);
        if (stream_en[4]) put(start_of(4), {temp, 16'b0}, 8);
        if (stream_en[3]) begin
            if (sup_short[1]) put(start_of(3), {sup2[9:2], 16'b0}, 8);
            else              put(start_of(3), {sup2, 14'b0}, 16);
        end
        if (stream_en[2]) begin
            if (sup_short[0]) put(start_of(2), {sup1[9:2], 16'b0}, 8);
            else              put(start_of(2), {sup1, 14'b0}, 16);
        end
        if (stream_en[1] && iv_len != 2'b10) begin
            if (iv_len == 2'b01) put(start_of(1), {isns[15:8], 16'b0}, 8);
            else                 put(start_of(1), {isns, 8'b0}, 16);
        end
        if (stream_en[0]) begin
            if (iv_len == 2'b01)      put(start_of(0), {vsns[15:8], 16'b0}, 8);
            else if (iv_len == 2'b10) put(start_of(0), {vsns[15:4], isns[15:4]}, 24);
            else                      put(start_of(0), {vsns, 8'b0}, 16);
        end
    endtask

    // one system clock: model the edge just taken, then compare
    task automatic step();
        @(negedge clk);
        if (!rst_n) begin
            m_prev_b = 0; m_prev_fs = 0; m_cnt = 100000;
            exp_sd = 0; exp_oe = 0;
        end else begin
            bit launch;
            launch = tx_fall ? (m_prev_b && !bclk) : (!m_prev_b && bclk);
            if (launch) begin
                int k;
                if (fsync && !m_prev_fs) begin
                    paint_frame();
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
                m_prev_fs = fsync;
                k = m_cnt - int'(slot_ofs);
                if (k >= 0 && k < 1024 && m_own[k]) begin
                    exp_sd = m_bit[k]; exp_oe = 1;
                end else begin
                    exp_sd = 0; exp_oe = !fill_hiz;
                end
            end
            m_prev_b = bclk;
        end
        n_checks++;
        if (sdout !== exp_sd || sdout_oe !== exp_oe) begin
            n_errors++;
            $display("FAIL %s: sdout=%b oe=%b, expected sdout=%b oe=%b at %0t",
                     cur_req, sdout, sdout_oe, exp_sd, exp_oe, $time);
        end
    endtask

    task automatic bit_period(bit fs);
        bclk  = tx_fall ? 1'b1 : 1'b0;
        fsync = fs;
        step(); step();
        bclk = ~bclk;
        step(); step();
    endtask

    task automatic run_frame(int nbits, bit mid_change);
        for (int b = 0; b < nbits; b++) begin
            bit_period(b == 0);
            if (mid_change && b == nbits / 2) begin
                vsns = ~vsns; isns = ~isns; temp = ~temp;
            end
        end
    endtask

    task automatic set_data(int s);
        vsns = 16'hA5C3 ^ 16'(s * 16'h1357);
        isns = 16'h3C96 ^ 16'(s * 16'h0B1D);
        sup1 = 10'h2D9 ^ 10'(s * 7);
        sup2 = 10'h15B ^ 10'(s * 13);
        temp = 8'h6E ^ 8'(s * 3);
        gain = 8'hB4 ^ 8'(s * 5);
        stat = 8'h4B ^ 8'(s * 11);
    endtask

    function automatic logic [41:0] slots(int v, int i, int p1, int p2, int t, int g, int st);
        return {6'(st), 6'(g), 6'(t), 6'(p2), 6'(p1), 6'(i), 6'(v)};
    endfunction

    initial begin
        // R1: reset state
        cur_req = "R1";
        set_data(0);
        repeat (4) step();
        rst_n = 1'b1;
        step();
        n_checks++;
        if (sdout !== 1'b0 || sdout_oe !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: after reset sdout=%b oe=%b, expected 0 0", sdout, sdout_oe);
        end
        stream_en = 7'b0000011;
        slot_idx  = slots(2, 0, 0, 0, 0, 0, 0);
        for (int b = 0; b < 4; b++) bit_period(1'b0);

        // R4: full 16-bit voltage and current at default slots
        cur_req = "R4";
        for (int f = 0; f < 2; f++) begin set_data(f + 1); run_frame(48, 0); end

        // R3: offset and MSB-first placement
        cur_req = "R3";
        slot_ofs = 3'd5;
        set_data(3); run_frame(48, 0);
        slot_ofs = 3'd1;
        slot_idx = slots(1, 3, 0, 0, 0, 0, 0);
        set_data(4); run_frame(48, 0);

        // R2: falling-edge launch
        cur_req = "R2";
        tx_fall = 1'b1;
        set_data(5); run_frame(48, 0);
        slot_ofs = 3'd7;
        set_data(6); run_frame(48, 0);
        tx_fall = 1'b0;
        slot_ofs = 3'd0;

        // R5: supply streams, long and short
        cur_req = "R5";
        stream_en = 7'b0001100;
        slot_idx  = slots(0, 0, 1, 4, 0, 0, 0);
        sup_short = 2'b00; set_data(7); run_frame(56, 0);
        sup_short = 2'b01; set_data(8); run_frame(56, 0);
        sup_short = 2'b10; set_data(9); run_frame(56, 0);
        sup_short = 2'b00;

        // R6: one-slot streams and individual enables
        cur_req = "R6";
        slot_idx  = slots(0, 0, 0, 0, 0, 2, 4);
        stream_en = 7'b1110000; set_data(10); run_frame(48, 0);
        stream_en = 7'b1010000; set_data(11); run_frame(48, 0);

        // R7: fill released to high impedance
        cur_req = "R7";
        fill_hiz = 1'b1;
        set_data(12); run_frame(48, 0);
        stream_en = 7'b0000000; run_frame(24, 0);
        fill_hiz = 1'b0;

        // R9: 8-bit voltage/current
        cur_req = "R9";
        iv_len = 2'b01;
        stream_en = 7'b0000011;
        slot_idx  = slots(1, 3, 0, 0, 0, 0, 0);
        set_data(13); run_frame(48, 0);

        // R10: packed 12-bit pair over three slots
        cur_req = "R10";
        iv_len = 2'b10;
        slot_idx  = slots(1, 2, 0, 0, 0, 0, 0);
        set_data(14); run_frame(48, 0);
        slot_idx  = slots(2, 5, 0, 0, 0, 0, 0);
        stream_en = 7'b1000011;
        slot_idx[41:36] = 6'd5;
        set_data(15); run_frame(56, 0);
        iv_len = 2'b00;

        // R11: overlapping enabled streams
        cur_req = "R11";
        stream_en = 7'b1110111;
        slot_idx  = slots(1, 2, 0, 0, 1, 3, 0);
        set_data(16); run_frame(48, 0);
        iv_len = 2'b10;
        slot_idx  = slots(0, 0, 2, 0, 1, 3, 0);
        set_data(17); run_frame(48, 0);
        iv_len = 2'b00;

        // R8: truncation at the frame boundary, and the top slot index
        cur_req = "R8";
        stream_en = 7'b0000001;
        slot_idx  = slots(2, 0, 0, 0, 0, 0, 0);
        slot_ofs  = 3'd2;
        for (int f = 0; f < 3; f++) begin set_data(18 + f); run_frame(20, 0); end
        slot_ofs  = 3'd0;
        stream_en = 7'b0100100;
        slot_idx  = slots(0, 0, 63, 0, 0, 63, 0);
        set_data(21); run_frame(530, 0);

        // R12: mid-frame changes stay out of the current frame
        cur_req = "R12";
        stream_en = 7'b0010011;
        slot_idx  = slots(0, 2, 0, 0, 4, 0, 0);
        set_data(22); run_frame(48, 1);
        set_data(23); run_frame(48, 1);
        run_frame(8, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule